// File: doc/BRIEF.md
# Graphics Token and Finish Interrupt Register Unit

This block is the CPU-visible register front end of a pixel stage in a graphics pipeline. A CPU reaches it over a 16-bit register bus; the rendering pipeline feeds it through sideband strobes. It holds five raster configuration words, a small control register, a 16-bit token value and four bounding-box words. It turns two pipeline events, "token reached" and "frame finished", into two interrupt lines that software can mask and acknowledge.

Pipeline events do not set their pending flags at once. They first sit for one cycle in a deferred-event register. A FIFO-attach cancel input works on the finish path. If the finish flag is already raised, the cancel clears it. Otherwise the cancel throws away a finish event that is still waiting in the deferred stage. The configuration words are storage only. The bounding-box words keep fixed values, and an active flag on them is cleared by any CPU read of them.

Top module: `gfx_irq_regs`

## Requirements
- R1: Only the low 12 bits of `cpu_addr` select a register. Upper address bits are ignored, so an aliased address reaches the same register.
- R2: The control register sits at offset 0x00A. Bit 0 holds the token interrupt enable and bit 1 holds the finish interrupt enable; both are written and read back. Bits 2 and 3 always read as 0.
- R3: A control write with bit 2 set clears the token pending flag, and one with bit 3 set clears the finish pending flag. A 0 in those bits leaves the flags unchanged.
- R4: `irq_token` equals token pending AND token enable, and `irq_finish` equals finish pending AND finish enable. `cause_vec` bit 9 mirrors `irq_token`, bit 10 mirrors `irq_finish`, and every other bit is 0.
- R5: A one-cycle pipeline event strobe sampled at clock edge k sets its pending flag at edge k+1. If an acknowledge lands on the cycle the deferred event sets the flag, the event wins.
- R6: `pipe_tok_wr` loads `pipe_tok_val` into the token register (offset 0x00E) and nothing else. `pipe_tok_irq` loads the value and also queues a token event.
- R7: A 16-bit CPU write to offset 0x00E leaves the token value unchanged. It pulses `cpu_err` high for exactly one cycle after the write edge.
- R8: The bounding-box words at offsets 0x010, 0x012, 0x014 and 0x016 read 0x0080, 0x00A0, 0x0080 and 0x00A0. `bbox_arm` sets `bbox_active`, and a CPU read of any of the four words clears it.
- R9: While the finish pending flag is 1, `fifo_attach` clears it, which drops `irq_finish`. While the flag is 0, `fifo_attach` discards a finish event held in the deferred stage, so the flag never rises.
- R10: A read of an unmapped offset returns 0x0001.
- R11: A write with `cpu_wide` high changes no register, clears no flag and raises no `cpu_err`.
- R12: `idle_ok` is high exactly when both interrupt enables are 0.
- R13: After reset, the configuration words, the control register, the token value and both pending flags are 0, and `bbox_active` is 0.
- R14: The configuration words sit at offsets 0x000, 0x002, 0x004, 0x006 and 0x008. Each stores and returns all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 32 | CPU byte address; the low 12 bits decode |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wide | input | 1 | Access is 32 bits wide (writes ignored) |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data for the addressed register |
| cpu_err | output | 1 | One-cycle strobe after a CPU write to the token register |
| pipe_tok_wr | input | 1 | Pipeline loads the token value |
| pipe_tok_irq | input | 1 | Pipeline loads the token value and raises a token event |
| pipe_tok_val | input | 16 | Token value from the pipeline |
| pipe_fin | input | 1 | Pipeline frame-finished event |
| fifo_attach | input | 1 | Cancel a raised or queued finish event |
| bbox_arm | input | 1 | Sets the bounding-box-active flag |
| bbox_active | output | 1 | Bounding-box-active flag |
| irq_token | output | 1 | Token interrupt |
| irq_finish | output | 1 | Finish interrupt |
| cause_vec | output | 16 | Interrupt cause vector (bit 9 token, bit 10 finish) |
| idle_ok | output | 1 | High when both interrupt enables are 0 |

## Verification
The bench builds the block with its default parameters: a 32-bit address decoded on 12 bits, 16-bit words, five configuration words, and cause bits 9 and 10. With these values, the bench can hit aliased addresses that differ only above bit 11. It can also read back the exact bits of the cause vector. The directed scenarios place event strobes, acknowledges and cancels on chosen cycles relative to the deferred-event stage, which makes the same-cycle event-versus-acknowledge case and both branches of the cancel observable at the interrupt pins.

// File: rtl/gfx_irq_pkg.sv
// Package: register offsets and reset constants shared by the interrupt
// register unit. Assumes 16-bit registers on even offsets.
package gfx_irq_pkg;
    localparam int DEC_W = 12;
    localparam int NUM_CFG = 5;
    localparam int NUM_BB = 4;

    localparam logic [DEC_W-1:0] OFS_CFG_BASE = 12'h000;
    localparam logic [DEC_W-1:0] OFS_CTRL     = 12'h00A;
    localparam logic [DEC_W-1:0] OFS_TOKEN    = 12'h00E;
    localparam logic [DEC_W-1:0] OFS_BB_BASE  = 12'h010;

    // Offset of configuration word i.
    function automatic logic [DEC_W-1:0] cfg_ofs(input int i);
        return OFS_CFG_BASE + DEC_W'(2 * i);
    endfunction

    // Offset of bounding-box word i (left, right, top, bottom).
    function automatic logic [DEC_W-1:0] bb_ofs(input int i);
        return OFS_BB_BASE + DEC_W'(2 * i);
    endfunction

    // Fixed bounding-box value: horizontal and vertical pairs alternate.
    function automatic logic [15:0] bb_value(input int i);
        return (i % 2 == 0) ? 16'h0080 : 16'h00A0;
    endfunction
endpackage

// File: rtl/gfx_irq_cfgbank.sv
// Module: bank of N plain storage words written by one-hot select.
// Assumes the caller has already qualified wr_en for width and address.
module gfx_irq_cfgbank #(
    parameter int N = 5,
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [N-1:0]      sel,
    input  logic [W-1:0]      wdata,
    output logic [N-1:0][W-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_word
        // Store one word on a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n)                q[i] <= '0;
            else if (wr_en && sel[i])  q[i] <= wdata;
        end
    end

    a_r14_unselected_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/gfx_irq_chan.sv
// Module: one interrupt channel. Holds a deferred-event register and a
// pending flag, and masks the flag with an enable. With CANCEL_EN set,
// cancel clears a raised flag or discards the queued event.
module gfx_irq_chan #(
    parameter bit CANCEL_EN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    input  logic ack,
    input  logic cancel,
    input  logic enable,
    output logic pend,
    output logic irq
);
    logic evt_q;
    logic drop_q;
    logic clr;

    assign drop_q = CANCEL_EN && cancel && !pend;
    assign clr    = ack || (CANCEL_EN && cancel);

    // Delay each pipeline event by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= evt_in;
    end

    // Pending flag: a landing event beats acknowledge and cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend <= 1'b0;
        else if (evt_q && !drop_q)  pend <= 1'b1;
        else if (clr)               pend <= 1'b0;
    end

    // Mask the flag onto the interrupt line.
    always_comb irq = pend && enable;

    a_r5_rise_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(evt_in, 2));
    a_r5_event_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && ack && !cancel) |=> pend);
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !evt_q && pend) |=> !pend);
    a_r9_cancel_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (CANCEL_EN && cancel && pend && !evt_q) |=> !pend);
    a_r9_cancel_discards_event: assert property (@(posedge clk) disable iff (!rst_n)
        (CANCEL_EN && cancel && !pend) |=> !pend);
endmodule

// File: rtl/gfx_irq_bbox.sv
// Module: bounding-box-active flag. The flag is set by the pipeline and
// cleared by any CPU read of a bounding-box word; set wins on a tie.
module gfx_irq_bbox (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic rd_hit,
    output logic active
);
    // Track the active flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      active <= 1'b0;
        else if (arm)    active <= 1'b1;
        else if (rd_hit) active <= 1'b0;
    end

    a_r8_read_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !arm) |=> !active);
endmodule

// File: rtl/gfx_irq_regs.sv
// Module: top of the token/finish interrupt register unit. Decodes the CPU
// bus on the low DEC_W address bits, stores the control enables and the
// token value, and routes pipeline events through two interrupt channels.
// Assumes single-cycle CPU strobes and a combinational read path.
module gfx_irq_regs
    import gfx_irq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 16,
    parameter int TOK_BIT = 9,
    parameter int FIN_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              cpu_wide,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_err,
    input  logic              pipe_tok_wr,
    input  logic              pipe_tok_irq,
    input  logic [DATA_W-1:0] pipe_tok_val,
    input  logic              pipe_fin,
    input  logic              fifo_attach,
    input  logic              bbox_arm,
    output logic              bbox_active,
    output logic              irq_token,
    output logic              irq_finish,
    output logic [DATA_W-1:0] cause_vec,
    output logic              idle_ok
);
    localparam int NCH = 2;

    logic [DEC_W-1:0]              ofs;
    logic                          unused_hi;
    logic                          wr16;
    logic [NUM_CFG-1:0]            cfg_sel;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
    logic                          ctrl_wr;
    logic                          tok_en, fin_en;
    logic [DATA_W-1:0]             tok_val;
    logic                          bb_hit;
    logic [NCH-1:0]                ch_evt, ch_ack, ch_cancel, ch_en, ch_pend, ch_irq;

    assign ofs       = cpu_addr[DEC_W-1:0];
    assign unused_hi = ^cpu_addr[ADDR_W-1:DEC_W];
    assign wr16      = cpu_wr && !cpu_wide;
    assign ctrl_wr   = wr16 && (ofs == OFS_CTRL);

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_sel
        assign cfg_sel[i] = (ofs == cfg_ofs(i));
    end

    gfx_irq_cfgbank #(.N(NUM_CFG), .W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr16), .sel(cfg_sel),
        .wdata(cpu_wdata), .q(cfg_q)
    );

    // Store the two interrupt enables from a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_en <= 1'b0;
            fin_en <= 1'b0;
        end else if (ctrl_wr) begin
            tok_en <= cpu_wdata[0];
            fin_en <= cpu_wdata[1];
        end
    end

    // Token value is loaded only by the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n)                           tok_val <= '0;
        else if (pipe_tok_wr || pipe_tok_irq) tok_val <= pipe_tok_val;
    end

    // Flag a CPU attempt to write the token register.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_err <= 1'b0;
        else        cpu_err <= wr16 && (ofs == OFS_TOKEN);
    end

    assign ch_evt    = {pipe_fin, pipe_tok_irq};
    assign ch_ack    = {ctrl_wr && cpu_wdata[3], ctrl_wr && cpu_wdata[2]};
    assign ch_cancel = {fifo_attach, 1'b0};
    assign ch_en     = {fin_en, tok_en};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gfx_irq_chan #(.CANCEL_EN(c == 1)) u_ch (
            .clk(clk), .rst_n(rst_n), .evt_in(ch_evt[c]), .ack(ch_ack[c]),
            .cancel(ch_cancel[c]), .enable(ch_en[c]),
            .pend(ch_pend[c]), .irq(ch_irq[c])
        );
    end

    assign irq_token  = ch_irq[0];
    assign irq_finish = ch_irq[1];
    assign idle_ok    = !tok_en && !fin_en;

    // Place the interrupt lines in the cause vector.
    always_comb begin
        cause_vec          = '0;
        cause_vec[TOK_BIT] = irq_token;
        cause_vec[FIN_BIT] = irq_finish;
    end

    // Read multiplexer; unmapped offsets return one.
    always_comb begin
        cpu_rdata = DATA_W'(1);
        bb_hit    = 1'b0;
        for (int i = 0; i < NUM_CFG; i++)
            if (cfg_sel[i]) cpu_rdata = cfg_q[i];
        for (int i = 0; i < NUM_BB; i++)
            if (ofs == bb_ofs(i)) begin
                cpu_rdata = DATA_W'(bb_value(i));
                bb_hit    = 1'b1;
            end
        if (ofs == OFS_CTRL)  cpu_rdata = {{(DATA_W-2){1'b0}}, fin_en, tok_en};
        if (ofs == OFS_TOKEN) cpu_rdata = tok_val;
    end

    gfx_irq_bbox u_bbox (
        .clk(clk), .rst_n(rst_n), .arm(bbox_arm),
        .rd_hit(cpu_rd && bb_hit), .active(bbox_active)
    );

    a_r7_token_cpu_proof: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_tok_wr && !pipe_tok_irq) |=> $stable(tok_val));
    a_r11_wide_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_wide && !cpu_rd) |=> !cpu_err && $stable(cfg_q) && $stable(tok_en) && $stable(fin_en));
    a_r2_ack_bits_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == OFS_CTRL) |-> cpu_rdata[3:2] == 2'b00);
    a_r4_cause_onehot_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause_vec) == $countones({irq_token, irq_finish}));
endmodule

// File: tb/gfx_irq_regs_test.sv
module gfx_irq_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_wide = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_err;
    logic        pipe_tok_wr = 1'b0, pipe_tok_irq = 1'b0;
    logic [15:0] pipe_tok_val = '0;
    logic        pipe_fin = 1'b0, fifo_attach = 1'b0, bbox_arm = 1'b0;
    logic        bbox_active, irq_token, irq_finish, idle_ok;
    logic [15:0] cause_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gfx_irq_regs uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wide(cpu_wide), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_err(cpu_err), .pipe_tok_wr(pipe_tok_wr),
        .pipe_tok_irq(pipe_tok_irq), .pipe_tok_val(pipe_tok_val),
        .pipe_fin(pipe_fin), .fifo_attach(fifo_attach), .bbox_arm(bbox_arm),
        .bbox_active(bbox_active), .irq_token(irq_token),
        .irq_finish(irq_finish), .cause_vec(cause_vec), .idle_ok(idle_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic [31:0] a, input logic [15:0] d, input logic wide);
        cpu_addr = a; cpu_wdata = d; cpu_wide = wide; cpu_wr = 1'b1;
        tick();
        cpu_wr = 1'b0; cpu_wide = 1'b0;
    endtask

    task automatic cpu_read(input logic [31:0] a, output logic [15:0] d);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        tick();
        cpu_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        cpu_read(32'h0, d);        check("R13 cfg0", d, 16'h0);
        cpu_read(32'h00A, d);      check("R13 ctrl", d, 16'h0);
        cpu_read(32'h00E, d);      check("R13 token", d, 16'h0);
        check("R13 irqs", {irq_token, irq_finish, bbox_active}, 3'b000);
        check("R12 idle after reset", idle_ok, 1'b1);
    endtask

    task automatic t_cfg();
        logic [15:0] d;
        for (int i = 0; i < 5; i++) cpu_write(32'(2 * i), 16'hBEE0 + 16'(i), 1'b0);
        for (int i = 0; i < 5; i++) begin
            cpu_read(32'(2 * i), d);
            check("R14 cfg word", d, 16'hBEE0 + 16'(i));
        end
        cpu_read(32'hCC00_0002, d); check("R1 aliased read", d, 16'hBEE1);
        cpu_write(32'h5A5A_F008, 16'h1357, 1'b0);
        cpu_read(32'h008, d);       check("R1 aliased write", d, 16'h1357);
    endtask

    task automatic t_ctrl();
        logic [15:0] d;
        cpu_write(32'h00A, 16'h000F, 1'b0);
        cpu_read(32'h00A, d);  check("R2 ctrl readback", d, 16'h0003);
        check("R12 idle with enables", idle_ok, 1'b0);
    endtask

    task automatic t_token();
        logic [15:0] d;
        pipe_tok_val = 16'h1234; pipe_tok_wr = 1'b1; tick(); pipe_tok_wr = 1'b0;
        tick(); tick();
        cpu_read(32'h00E, d);  check("R6 plain token value", d, 16'h1234);
        check("R6 plain write no irq", irq_token, 1'b0);
        pipe_tok_val = 16'h5678; pipe_tok_irq = 1'b1; tick(); pipe_tok_irq = 1'b0;
        check("R5 not yet pending", irq_token, 1'b0);
        tick();
        check("R5 token irq after delay", irq_token, 1'b1);
        check("R4 cause token", cause_vec, 16'h0200);
        cpu_read(32'h00E, d);  check("R6 irq token value", d, 16'h5678);
        cpu_write(32'h00A, 16'h0002, 1'b0);
        check("R4 masked token", irq_token, 1'b0);
        cpu_write(32'h00A, 16'h0003, 1'b0);
        check("R3 zero ack keeps flag", irq_token, 1'b1);
        cpu_write(32'h00A, 16'h0007, 1'b0);
        check("R3 ack clears token", irq_token, 1'b0);
    endtask

    task automatic t_cpu_token();
        logic [15:0] d;
        cpu_write(32'h00E, 16'hFFFF, 1'b0);
        check("R7 err strobe", cpu_err, 1'b1);
        tick();
        check("R7 err one cycle", cpu_err, 1'b0);
        cpu_read(32'h00E, d);  check("R7 token kept", d, 16'h5678);
    endtask

    task automatic t_finish();
        pipe_fin = 1'b1; tick(); pipe_fin = 1'b0;
        check("R5 finish not yet", irq_finish, 1'b0);
        tick();
        check("R5 finish irq", irq_finish, 1'b1);
        check("R4 cause finish", cause_vec, 16'h0400);
        pipe_fin = 1'b1; tick(); pipe_fin = 1'b0;
        cpu_write(32'h00A, 16'h000B, 1'b0);
        check("R5 event beats ack", irq_finish, 1'b1);
    endtask

    task automatic t_cancel();
        fifo_attach = 1'b1; tick(); fifo_attach = 1'b0;
        check("R9 cancel drops raised", irq_finish, 1'b0);
        pipe_fin = 1'b1; tick(); pipe_fin = 1'b0;
        fifo_attach = 1'b1; tick(); fifo_attach = 1'b0;
        tick(); tick();
        check("R9 cancel discards queued", irq_finish, 1'b0);
    endtask

    task automatic t_wide();
        logic [15:0] d;
        pipe_fin = 1'b1; tick(); pipe_fin = 1'b0; tick();
        cpu_write(32'h00A, 16'h0008, 1'b1);
        check("R11 wide ack ignored", irq_finish, 1'b1);
        cpu_read(32'h00A, d);  check("R11 ctrl kept", d, 16'h0003);
        cpu_write(32'h00E, 16'h0000, 1'b1);
        check("R11 wide token no err", cpu_err, 1'b0);
        cpu_write(32'h004, 16'hAAAA, 1'b1);
        cpu_read(32'h004, d);  check("R11 cfg kept", d, 16'hBEE2);
    endtask

    task automatic t_bbox();
        logic [15:0] d;
        bbox_arm = 1'b1; tick(); bbox_arm = 1'b0;
        check("R8 arm sets active", bbox_active, 1'b1);
        cpu_read(32'h010, d);  check("R8 bbox left", d, 16'h0080);
        check("R8 read clears active", bbox_active, 1'b0);
        cpu_read(32'h012, d);  check("R8 bbox right", d, 16'h00A0);
        cpu_read(32'h014, d);  check("R8 bbox top", d, 16'h0080);
        cpu_read(32'h016, d);  check("R8 bbox bottom", d, 16'h00A0);
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        cpu_read(32'h0C0, d);  check("R10 unmapped", d, 16'h0001);
        cpu_read(32'h00C, d);  check("R10 gap offset", d, 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_cfg();
        t_ctrl();
        t_token();
        t_cpu_token();
        t_finish();
        t_cancel();
        t_wide();
        t_bbox();
        t_unmapped();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule